// File: doc/BRIEF.md
# Quad I/O Serial Flash Read Controller

This block sits on the host side of a serial NOR flash and fetches a run of consecutive bytes with the quad input/output fast-read command (opcode 0xEB). A requester presents a 24-bit start address, a byte count, a mode select and a serial-clock divider, and holds its request until the block pulses an acknowledge. The block drives chip select, the serial clock and four data lines, each with its own output enable, and returns every assembled byte on a valid/ready stream.

Two command modes are offered. In single-line mode the opcode goes out one bit per clock on DQ0. In all-lines mode the opcode goes out one nibble per clock, so it takes two clocks. In both modes the address, the dummy gap and the data use all four lines. The flash advances its own address after each byte, so one command covers any length, including a run that crosses the top of the address space. A stalled consumer freezes the serial clock with chip select held low, and an abort input ends the transfer early during the data phase.

Top module: `qspi_quad_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, all four output enables are off, and both the byte valid and the acknowledge are low.
- R2: The opcode 0xEB is sent MSB first. With req_quad low it takes eight clocks on DQ0 only (enable pattern 4'b0001). With req_quad high it takes two clocks on DQ3..DQ0, high nibble first (enable pattern 4'b1111).
- R3: The 24-bit address follows the opcode in six clocks with all four enables on. The most significant nibble goes first, and DQ3 carries the highest bit of each nibble.
- R4: After the address come exactly six dummy clocks and then the data phase. The controller drives no line (enables 4'b0000) from the first dummy clock until chip select rises.
- R5: Each byte spans two serial clocks. The nibble sampled on the first rising edge becomes rd_data[7:4] and the one sampled on the second becomes rd_data[3:0]. Bytes leave in address order, exactly req_len of them, and a byte held with rd_ready low keeps its value.
- R6: The serial clock idles low, and outputs change only on its falling edges. Each half-period lasts req_div+1 system clocks, so the first rising edge comes req_div+1 cycles after chip select falls.
- R7: While a byte is pending and rd_ready is low, the serial clock stays low and chip select stays low in the data phase. No byte is lost or repeated when the transfer resumes.
- R8: When the last byte has been clocked, chip select rises and ack pulses high for one cycle with chip select high. A request with req_len of zero is acknowledged in the cycle after acceptance and chip select never falls.
- R9: Raising abort during the data phase brings chip select high and pulses ack within req_div+3 cycles. At most one more byte is delivered after the byte count at which abort was raised.
- R10: A run that passes address 0xFFFFFF is fetched with one command. The bytes continue from address 0 in the flash's wrapped order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Transfer request, held until ack |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes to fetch |
| req_quad | input | 1 | 1: opcode on four lines, 0: opcode on DQ0 |
| req_div | input | DIV_W | Serial clock half-period minus one, in system clocks |
| ack | output | 1 | One-cycle completion pulse |
| abort | input | 1 | End the transfer early during the data phase |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| dq_out | output | 4 | Values driven onto DQ3..DQ0 |
| dq_oe | output | 4 | Per-line output enables |
| dq_in | input | 4 | Values read from DQ3..DQ0 |
| rd_data | output | 8 | Assembled byte |
| rd_valid | output | 1 | rd_data holds a byte |
| rd_ready | input | 1 | Consumer accepts the byte |

## Verification
Timing is checked in system-clock cycles counted from the stimulus. The first serial rising edge must come exactly req_div+1 cycles after chip select falls. A zero-length request must be acknowledged in the first cycle after acceptance. An abort must raise chip select and ack within req_div+3 cycles. The bench drives inputs and samples outputs on falling system-clock edges, so each count covers every register on the path. A behavioural flash model records the opcode, address and enable patterns on every serial edge and returns computed data. Each byte received is compared with a value computed from the wrapped address.

// File: rtl/qspi_quad_reader.sv
module qspi_quad_reader #(
  parameter int LEN_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_quad,
  input  logic [DIV_W-1:0] req_div,
  output logic             ack,
  input  logic             abort,
  output logic             cs_n,
  output logic             sck,
  output logic [3:0]       dq_out,
  output logic [3:0]       dq_oe,
  input  logic [3:0]       dq_in,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready
);

  localparam logic [7:0] OPCODE    = 8'hEB;
  localparam logic [2:0] ADDR_LAST = 3'd5;
  localparam logic [2:0] GAP_LAST  = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_CMD = 3'd1, S_ADDR = 3'd2,
    S_GAP = 3'd3, S_DATA = 3'd4, S_DONE = 3'd5
  } st_t;

  st_t              st;
  logic             quad;
  logic [DIV_W-1:0] div_q, div_cnt;
  logic [31:0]      sh;
  logic [2:0]       cnt;
  logic [LEN_W-1:0] left;
  logic             half;
  logic [3:0]       nib_hi;

  wire       active   = (st == S_CMD) || (st == S_ADDR) || (st == S_GAP) || (st == S_DATA);
  wire       stall    = rd_valid && !rd_ready;
  wire       hold     = (st == S_DATA) && !sck && stall;
  wire       tick     = active && (div_cnt == div_q);
  wire       quit     = (st == S_DATA) && !sck && abort;
  wire       rise     = tick && !sck && !hold && !quit;
  wire       fall     = tick && sck;
  wire [2:0] cmd_last = quad ? 3'd1 : 3'd7;

  assign cs_n = !active;
  assign ack  = (st == S_DONE);

  always_comb begin
    dq_out = 4'b0000;
    dq_oe  = 4'b0000;
    if (st == S_CMD) begin
      if (quad) begin
        dq_out = sh[31:28];
        dq_oe  = 4'b1111;
      end else begin
        dq_out = {3'b000, sh[31]};
        dq_oe  = 4'b0001;
      end
    end else if (st == S_ADDR) begin
      dq_out = sh[31:28];
      dq_oe  = 4'b1111;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      quad     <= 1'b0;
      div_q    <= '0;
      div_cnt  <= '0;
      sh       <= '0;
      cnt      <= '0;
      left     <= '0;
      half     <= 1'b0;
      nib_hi   <= '0;
      sck      <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (active && !hold) div_cnt <= tick ? '0 : div_cnt + 1'b1;
      case (st)
        S_IDLE: begin
          if (req) begin
            quad    <= req_quad;
            div_q   <= req_div;
            sh      <= {OPCODE, req_addr};
            left    <= req_len;
            cnt     <= '0;
            half    <= 1'b0;
            div_cnt <= '0;
            st      <= (req_len == '0) ? S_DONE : S_CMD;
          end
        end
        S_DONE: st <= S_IDLE;
        default: begin
          if (quit) begin
            st <= S_DONE;
          end else if (rise) begin
            sck <= 1'b1;
            if (st == S_DATA) begin
              if (!half) begin
                nib_hi <= dq_in;
                half   <= 1'b1;
              end else begin
                rd_data  <= {nib_hi, dq_in};
                rd_valid <= 1'b1;
                left     <= left - 1'b1;
                half     <= 1'b0;
              end
            end
          end else if (fall) begin
            sck <= 1'b0;
            cnt <= cnt + 3'd1;
            case (st)
              S_CMD: begin
                sh <= quad ? (sh << 4) : (sh << 1);
                if (cnt == cmd_last) begin
                  st  <= S_ADDR;
                  cnt <= '0;
                end
              end
              S_ADDR: begin
                sh <= sh << 4;
                if (cnt == ADDR_LAST) begin
                  st  <= S_GAP;
                  cnt <= '0;
                end
              end
              S_GAP: begin
                if (cnt == GAP_LAST) begin
                  st  <= S_DATA;
                  cnt <= '0;
                end
              end
              default: begin
                if (left == '0 && !half) st <= S_DONE;
              end
            endcase
          end
        end
      endcase
    end
  end

endmodule

module qspi_quad_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic [3:0] dq_oe,
  input logic       ack,
  input logic       abort,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic [2:0] st
);
  localparam logic [2:0] IN_DATA = 3'd4;

  assert_cs_sck_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  assert_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (dq_oe == 4'b0000));

  assert_byte_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_no_clock_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IN_DATA && rd_valid && !rd_ready && !sck && !abort) |=> (!sck && !cs_n));

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_ack_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> cs_n);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IN_DATA && abort && !sck) |=> cs_n);
endmodule

bind qspi_quad_reader qspi_quad_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .dq_oe(dq_oe),
  .ack(ack), .abort(abort), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .st(st)
);

// File: tb/qspi_quad_reader_bench.sv
`timescale 1ns/1ps
module qspi_quad_reader_bench;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, req_quad = 0, abort = 0, rd_ready = 0;
  logic [23:0] req_addr = 0;
  logic [15:0] req_len = 0;
  logic [7:0]  req_div = 0;
  logic        ack, cs_n, sck, rd_valid;
  logic [3:0]  dq_out, dq_oe, dq_in = 0;
  logic [7:0]  rd_data;

  int checks = 0, failures = 0, cyc = 0;
  int ready_pct = 100, got = 0, data_err = 0;
  logic [23:0] base = 0;

  bit          fl_quad = 0;
  logic [7:0]  fl_op = 0;
  logic [23:0] fl_addr = 0;
  int          rcnt = 0, nk = 0, fl_oe_err = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qspi_quad_reader u_qspi_quad_reader (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_len(req_len),
    .req_quad(req_quad), .req_div(req_div), .ack(ack), .abort(abort),
    .cs_n(cs_n), .sck(sck), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready));

  function automatic logic [7:0] mem(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[23:21]} ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic int cmd_clks(input bit q);
    return q ? 2 : 8;
  endfunction

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // behavioural flash
  always @(negedge cs_n) begin
    rcnt = 0; nk = 0; fl_op = 0; fl_addr = 0;
  end

  always @(posedge sck) if (!cs_n) begin
    if (rcnt < cmd_clks(fl_quad)) begin
      if (fl_quad) begin
        fl_op = {fl_op[3:0], dq_out};
        if (dq_oe != 4'b1111) fl_oe_err++;
      end else begin
        fl_op = {fl_op[6:0], dq_out[0]};
        if (dq_oe != 4'b0001) fl_oe_err++;
      end
    end else if (rcnt < cmd_clks(fl_quad) + 6) begin
      fl_addr = {fl_addr[19:0], dq_out};
      if (dq_oe != 4'b1111) fl_oe_err++;
    end else if (dq_oe != 4'b0000) begin
      fl_oe_err++;
    end
    rcnt++;
  end

  always @(negedge sck) if (!cs_n && rcnt >= cmd_clks(fl_quad) + 12) begin
    logic [7:0] b;
    b = mem(fl_addr + 24'(nk / 2));
    dq_in = (nk % 2 == 0) ? b[7:4] : b[3:0];
    nk++;
  end

  // consumer
  always @(negedge clk) begin
    rd_ready = ($urandom % 100) < ready_pct;
    if (rd_valid && rd_ready) begin
      if (rd_data != mem(base + 24'(got))) begin
        data_err++;
        $display("FAIL R5: byte %0d actual=%0h expected=%0h", got, rd_data, mem(base + 24'(got)));
      end
      got++;
    end
  end

  task automatic xfer(input logic [23:0] a, input int n, input bit q, input int d,
                      input int rp, input int ab, input int stall);
    int cs_c, sk_c, ab_c, ack_c, wait_n, r_at;
    bit ack_seen, ab_sent, stall_done;
    @(negedge clk);
    fl_quad = q; base = a; got = 0; data_err = 0; fl_oe_err = 0;
    ready_pct = (stall > 0) ? 0 : rp;
    req = 1; req_addr = a; req_len = 16'(n); req_quad = q; req_div = 8'(d);
    cs_c = -1; sk_c = -1; ab_c = -1; ack_c = -1; wait_n = 0;
    ack_seen = 0; ab_sent = 0; stall_done = 0;
    for (int i = 0; i < 50000 && !ack_seen; i++) begin
      @(negedge clk);
      wait_n++;
      if (!cs_n && cs_c < 0) cs_c = cyc;
      if (sck && sk_c < 0) sk_c = cyc;
      if (ab > 0 && !ab_sent && got >= ab) begin
        abort = 1; ab_sent = 1; ab_c = cyc;
      end
      if (stall > 0 && !stall_done && rd_valid) begin
        r_at = rcnt;
        repeat (stall) @(negedge clk);
        check(rcnt == r_at, "R7 clock frozen", rcnt, r_at);
        check(!sck && !cs_n && rd_valid, "R7 stall state", {sck, cs_n, rd_valid}, 3'b001);
        ready_pct = rp; stall_done = 1;
      end
      if (ack) begin
        ack_seen = 1; ack_c = cyc;
        check(cs_n, "R8 cs high at ack", cs_n, 1);
      end
    end
    req = 0; abort = 0;
    check(ack_seen, "R8 ack seen", ack_seen, 1);
    for (int i = 0; i < 2000 && rd_valid; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    if (n == 0) begin
      check(wait_n == 1, "R8 zero-length ack latency", wait_n, 1);
      check(cs_c < 0, "R8 zero-length no select", cs_c, -1);
      return;
    end
    check(fl_op == 8'hEB, q ? "R2 opcode quad" : "R2 opcode single", fl_op, 8'hEB);
    check(fl_addr == a, "R3 address", fl_addr, a);
    check(fl_oe_err == 0, "R4 enable pattern", fl_oe_err, 0);
    check(sk_c - cs_c == d + 1, "R6 first rise latency", sk_c - cs_c, d + 1);
    check(data_err == 0, "R5 data", data_err, 0);
    if (ab > 0) begin
      check(ack_c - ab_c <= d + 3, "R9 abort latency", ack_c - ab_c, d + 3);
      check(got <= ab + 1 && got < n, "R9 bytes after abort", got, ab);
    end else begin
      check(got == n, "R5 byte count", got, n);
    end
  endtask

  initial begin
    #1520000;
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cs_n && !sck && dq_oe == 0 && !rd_valid && !ack, "R1 reset state",
          {cs_n, sck, dq_oe, rd_valid, ack}, 8'b1_0_0000_0_0);
    xfer(24'h123456, 5, 0, 0, 100, 0, 0);
    xfer(24'hA5C3E1, 3, 1, 2, 100, 0, 0);
    xfer(24'h000010, 0, 0, 1, 100, 0, 0);
    xfer(24'hFFFFFE, 4, 1, 1, 100, 0, 0);   // R10 wrap across top
    check(got == 4 && data_err == 0, "R10 wrap order", got, 4);
    xfer(24'h000100, 4, 0, 1, 100, 0, 60);  // R7 stall
    xfer(24'h3FF000, 20, 0, 1, 100, 3, 0);  // R9 abort
    xfer(24'h00ABCD, 16, 1, 0, 100, 2, 0);  // R9 abort quad
    for (int t = 0; t < 12; t++) begin
      xfer(24'($urandom), 1 + int'($urandom % 24), bit'($urandom % 2),
           int'($urandom % 4), 30 + int'($urandom % 71), 0, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule